// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block changes the divider settings of an integer PLL without ever feeding a half-configured clock to the logic downstream. A requester presents a new input divider, output divider, feedback multiplier and loop-bandwidth value, then pulses `start`. The sequencer first moves the downstream clock selector onto the slow reference if it was driving the normal PLL output. It then holds the PLL in reset and writes the four divider fields one after another. After that it releases reset, waits a settling time that grows with the input divider, and polls the PLL lock flag for a bounded number of cycles.

If lock is seen, the new settings stay in place. If the poll window runs out, the sequencer reloads the settings that were active before the request, using the same reset-and-load sequence. It does this once only, and it reports an error when it finishes. The selector goes back to the normal output only when the operation ends, and only if it was there at the start. A one-cycle `done` pulse, with `err` valid in the same cycle, closes every accepted request.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `sel_we`, `pll_reset` and `fld_wr` are low, and all four divider fields read zero.
- R2: Selector encoding is 0 = slow reference, 1 = normal PLL output, 2 = deep-slow source. If `sel_cur` is 1 when a request is accepted, the block writes 0 through `sel_we`/`sel_wdata` before `pll_reset` rises. It writes 1 back only after `pll_reset` has fallen, as the last step before `done`.
- R3: Each load pass writes the fields one per cycle in the fixed order NR, NO, NF, NB. These map to `fld_wr` bits 0, 1, 2 and 3, with at most one bit high at a time. Every write happens while `pll_reset` is high, and `pll_reset` falls only after the NB write.
- R4: Each divider field holds the requested value minus one. Requested values are the real ratios, from 1 up to 2^width.
- R5: After `pll_reset` falls, the block counts floor(NR*500/24)+1 cycles in which `tick_us` is high before it looks at `pll_lock`. Here NR is the real input divider of that pass.
- R6: During polling, the first cycle with `pll_lock` high ends the pass as a success. With `tick_us` held high, `done` arrives exactly 9 + settle-ticks cycles after the clock edge that accepted `start`.
- R7: If `pll_lock` stays low for POLL_LIMIT polling cycles, the block runs the full reset/load/settle/poll sequence again with the settings that were active before the request. It then finishes with `err` = 1.
- R8: A timeout during that restore pass does not start another restore. The block finishes with `err` = 1, and the fields hold the restored settings.
- R9: `done` is high for exactly one cycle, with `busy` already low and `err` valid in that cycle.
- R10: If `sel_cur` is not 1 when a request is accepted, the block makes no selector write at all.
- R11: A `start` pulse while `busy` is high is ignored. It produces no extra `done` and does not change the settings being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| req_nr | input | NR_W+1 | Requested input divider (real value) |
| req_no | input | NO_W+1 | Requested output divider (real value) |
| req_nf | input | NF_W+1 | Requested feedback multiplier (real value) |
| req_nb | input | NB_W+1 | Requested bandwidth value (real value) |
| sel_cur | input | 2 | Present clock selector setting |
| pll_lock | input | 1 | PLL lock status |
| tick_us | input | 1 | One-microsecond timebase strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Lock failure, valid with done |
| sel_we | output | 1 | Selector write strobe |
| sel_wdata | output | 2 | Selector write value |
| pll_reset | output | 1 | PLL reset control |
| fld_wr | output | 4 | Field write strobes (bit0 NR .. bit3 NB) |
| fld_nr | output | NR_W | Input divider field (value minus one) |
| fld_no | output | NO_W | Output divider field (value minus one) |
| fld_nf | output | NF_W | Feedback field (value minus one) |
| fld_nb | output | NB_W | Bandwidth field (value minus one) |

## Verification
The assertions assume three things about the environment. First, `sel_cur` follows the selector register that `sel_we` writes. Second, requested divider values are never zero. Third, `start` is a single-cycle pulse. Beyond that, `pll_lock` and `tick_us` may change in any cycle. The bench keeps within these assumptions: it models the selector as a register loaded only by `sel_we`, it uses only ratios from 1 to full scale, and it drives `pll_lock` either as a constant or as a function of the NF field. That last choice makes the PLL refuse one chosen multiplier, which exercises a restore pass that succeeds. The bench also drives `tick_us` either continuously or on alternate cycles, so the settle count is exercised under a gated timebase.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PARK,
    ST_RST_ON,
    ST_LD_NR,
    ST_LD_NO,
    ST_LD_NF,
    ST_LD_NB,
    ST_RST_OFF,
    ST_SETTLE,
    ST_POLL,
    ST_UNPARK
  } seq_state_e;

  localparam logic [1:0] SEL_SLOW = 2'd0;
  localparam logic [1:0] SEL_NORM = 2'd1;
  localparam logic [1:0] SEL_DEEP = 2'd2;

  // settling delay in microsecond ticks for a real input divider value
  function automatic int unsigned settle_ticks(input int unsigned nr);
    return (nr * 500) / 24 + 1;
  endfunction

endpackage

// File: rtl/div_field_reg.sv
module div_field_reg #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= d;
  end

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer import pll_seq_pkg::*; #(
  parameter int unsigned NR_W       = 6,
  parameter int unsigned ST_W       = 11,
  parameter int unsigned PC_W       = 25,
  parameter int unsigned POLL_LIMIT = 24_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            settle_load,
  input  logic [NR_W-1:0] nr_field,
  input  logic            tick_us,
  input  logic            in_settle,
  input  logic            in_poll,
  output logic            settle_expire,
  output logic            poll_expire
);

  logic [ST_W-1:0] settle_cnt;
  logic [PC_W-1:0] poll_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
    end else if (settle_load) begin
      settle_cnt <= ST_W'(settle_ticks(32'(nr_field) + 32'd1));
    end else if (in_settle && tick_us && settle_cnt != '0) begin
      settle_cnt <= settle_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        poll_cnt <= '0;
    else if (!in_poll) poll_cnt <= '0;
    else               poll_cnt <= poll_cnt + 1'b1;
  end

  assign settle_expire = in_settle && tick_us && (settle_cnt == ST_W'(1));
  assign poll_expire   = in_poll && (poll_cnt == PC_W'(POLL_LIMIT - 1));

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl import pll_seq_pkg::*; #(
  parameter int unsigned NR_W = 6,
  parameter int unsigned NO_W = 4,
  parameter int unsigned NF_W = 13,
  parameter int unsigned NB_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NR_W:0]   req_nr,
  input  logic [NO_W:0]   req_no,
  input  logic [NF_W:0]   req_nf,
  input  logic [NB_W:0]   req_nb,
  input  logic [NR_W-1:0] cur_nr,
  input  logic [NO_W-1:0] cur_no,
  input  logic [NF_W-1:0] cur_nf,
  input  logic [NB_W-1:0] cur_nb,
  input  logic [1:0]      sel_cur,
  input  logic            pll_lock,
  input  logic            settle_expire,
  input  logic            poll_expire,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            sel_we,
  output logic [1:0]      sel_wdata,
  output logic            pll_reset,
  output logic [3:0]      fld_wr,
  output logic [NR_W-1:0] tgt_nr,
  output logic [NO_W-1:0] tgt_no,
  output logic [NF_W-1:0] tgt_nf,
  output logic [NB_W-1:0] tgt_nb,
  output logic            settle_load,
  output logic            in_settle,
  output logic            in_poll,
  output logic            poll_timeout,
  output logic            in_rollback
);

  seq_state_e      state;
  logic            was_norm;
  logic            failed;
  logic [NR_W-1:0] sv_nr;
  logic [NO_W-1:0] sv_no;
  logic [NF_W-1:0] sv_nf;
  logic [NB_W-1:0] sv_nb;

  assign busy         = (state != ST_IDLE);
  assign in_settle    = (state == ST_SETTLE);
  assign in_poll      = (state == ST_POLL);
  assign settle_load  = (state == ST_RST_OFF);
  assign poll_timeout = in_poll && !pll_lock && poll_expire;
  assign sel_we       = was_norm && (state == ST_PARK || state == ST_UNPARK);
  assign sel_wdata    = (state == ST_PARK) ? SEL_SLOW : SEL_NORM;

  always_comb begin
    fld_wr = 4'b0000;
    case (state)
      ST_LD_NR: fld_wr = 4'b0001;
      ST_LD_NO: fld_wr = 4'b0010;
      ST_LD_NF: fld_wr = 4'b0100;
      ST_LD_NB: fld_wr = 4'b1000;
      default:  fld_wr = 4'b0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      was_norm    <= 1'b0;
      failed      <= 1'b0;
      in_rollback <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      pll_reset   <= 1'b0;
      tgt_nr      <= '0;
      tgt_no      <= '0;
      tgt_nf      <= '0;
      tgt_nb      <= '0;
      sv_nr       <= '0;
      sv_no       <= '0;
      sv_nf       <= '0;
      sv_nb       <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            tgt_nr      <= NR_W'(req_nr - 1'b1);
            tgt_no      <= NO_W'(req_no - 1'b1);
            tgt_nf      <= NF_W'(req_nf - 1'b1);
            tgt_nb      <= NB_W'(req_nb - 1'b1);
            sv_nr       <= cur_nr;
            sv_no       <= cur_no;
            sv_nf       <= cur_nf;
            sv_nb       <= cur_nb;
            was_norm    <= (sel_cur == SEL_NORM);
            in_rollback <= 1'b0;
            failed      <= 1'b0;
            state       <= ST_PARK;
          end
        end
        ST_PARK:   state <= ST_RST_ON;
        ST_RST_ON: begin
          pll_reset <= 1'b1;
          state     <= ST_LD_NR;
        end
        ST_LD_NR:  state <= ST_LD_NO;
        ST_LD_NO:  state <= ST_LD_NF;
        ST_LD_NF:  state <= ST_LD_NB;
        ST_LD_NB:  state <= ST_RST_OFF;
        ST_RST_OFF: begin
          pll_reset <= 1'b0;
          state     <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_expire) state <= ST_POLL;
        ST_POLL: begin
          if (pll_lock) begin
            state <= ST_UNPARK;
          end else if (poll_timeout) begin
            failed <= 1'b1;
            if (!in_rollback) begin
              in_rollback <= 1'b1;
              tgt_nr      <= sv_nr;
              tgt_no      <= sv_no;
              tgt_nf      <= sv_nf;
              tgt_nb      <= sv_nb;
              state       <= ST_RST_ON;
            end else begin
              state <= ST_UNPARK;
            end
          end
        end
        ST_UNPARK: begin
          done  <= 1'b1;
          err   <= failed;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq import pll_seq_pkg::*; #(
  parameter int unsigned NR_W       = 6,
  parameter int unsigned NO_W       = 4,
  parameter int unsigned NF_W       = 13,
  parameter int unsigned NB_W       = 12,
  parameter int unsigned POLL_LIMIT = 24_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NR_W:0]   req_nr,
  input  logic [NO_W:0]   req_no,
  input  logic [NF_W:0]   req_nf,
  input  logic [NB_W:0]   req_nb,
  input  logic [1:0]      sel_cur,
  input  logic            pll_lock,
  input  logic            tick_us,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            sel_we,
  output logic [1:0]      sel_wdata,
  output logic            pll_reset,
  output logic [3:0]      fld_wr,
  output logic [NR_W-1:0] fld_nr,
  output logic [NO_W-1:0] fld_no,
  output logic [NF_W-1:0] fld_nf,
  output logic [NB_W-1:0] fld_nb
);

  localparam int unsigned MAX_SETTLE = settle_ticks(32'd1 << NR_W);
  localparam int unsigned ST_W       = $clog2(MAX_SETTLE + 1);
  localparam int unsigned PC_W       = $clog2(POLL_LIMIT + 1);

  // internal events, named for the checker
  logic            ev_settle_load;
  logic            ev_settle_active;
  logic            ev_settle_expire;
  logic            ev_poll_active;
  logic            ev_poll_expire;
  logic            ev_poll_timeout;
  logic            ev_rollback;
  logic [NR_W-1:0] tgt_nr;
  logic [NO_W-1:0] tgt_no;
  logic [NF_W-1:0] tgt_nf;
  logic [NB_W-1:0] tgt_nb;

  pll_seq_ctrl #(
    .NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W), .NB_W(NB_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .req_nr       (req_nr),
    .req_no       (req_no),
    .req_nf       (req_nf),
    .req_nb       (req_nb),
    .cur_nr       (fld_nr),
    .cur_no       (fld_no),
    .cur_nf       (fld_nf),
    .cur_nb       (fld_nb),
    .sel_cur      (sel_cur),
    .pll_lock     (pll_lock),
    .settle_expire(ev_settle_expire),
    .poll_expire  (ev_poll_expire),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .sel_we       (sel_we),
    .sel_wdata    (sel_wdata),
    .pll_reset    (pll_reset),
    .fld_wr       (fld_wr),
    .tgt_nr       (tgt_nr),
    .tgt_no       (tgt_no),
    .tgt_nf       (tgt_nf),
    .tgt_nb       (tgt_nb),
    .settle_load  (ev_settle_load),
    .in_settle    (ev_settle_active),
    .in_poll      (ev_poll_active),
    .poll_timeout (ev_poll_timeout),
    .in_rollback  (ev_rollback)
  );

  pll_seq_timer #(
    .NR_W(NR_W), .ST_W(ST_W), .PC_W(PC_W), .POLL_LIMIT(POLL_LIMIT)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .settle_load  (ev_settle_load),
    .nr_field     (tgt_nr),
    .tick_us      (tick_us),
    .in_settle    (ev_settle_active),
    .in_poll      (ev_poll_active),
    .settle_expire(ev_settle_expire),
    .poll_expire  (ev_poll_expire)
  );

  div_field_reg #(.W(NR_W)) u_reg_nr (
    .clk(clk), .rst_n(rst_n), .we(fld_wr[0]), .d(tgt_nr), .q(fld_nr));
  div_field_reg #(.W(NO_W)) u_reg_no (
    .clk(clk), .rst_n(rst_n), .we(fld_wr[1]), .d(tgt_no), .q(fld_no));
  div_field_reg #(.W(NF_W)) u_reg_nf (
    .clk(clk), .rst_n(rst_n), .we(fld_wr[2]), .d(tgt_nf), .q(fld_nf));
  div_field_reg #(.W(NB_W)) u_reg_nb (
    .clk(clk), .rst_n(rst_n), .we(fld_wr[3]), .d(tgt_nb), .q(fld_nb));

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk import pll_seq_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       sel_we,
  input logic [1:0] sel_wdata,
  input logic       pll_reset,
  input logic [3:0] fld_wr,
  input logic       poll_active,
  input logic       settle_expire,
  input logic       poll_timeout,
  input logic       rollback
);

  AST_WR_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_wr != 4'b0000) |-> pll_reset);                                   // R3
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fld_wr));                                                    // R3
  AST_NORM_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_wdata == SEL_NORM) |-> !pll_reset);                    // R2
  AST_NO_POLL_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    poll_active |-> !pll_reset);                                          // R5
  AST_SETTLE_BEFORE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(poll_active) |-> $past(settle_expire));                         // R5
  AST_ROLLBACK_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rollback) |-> $past(poll_timeout));                             // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                      // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                      // R9

endmodule

bind pll_reprog_seq pll_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .sel_we       (sel_we),
  .sel_wdata    (sel_wdata),
  .pll_reset    (pll_reset),
  .fld_wr       (fld_wr),
  .poll_active  (ev_poll_active),
  .settle_expire(ev_settle_expire),
  .poll_timeout (ev_poll_timeout),
  .rollback     (ev_rollback)
);

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NR_W = 6, NO_W = 4, NF_W = 13, NB_W = 12;
  localparam int POLL = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NR_W:0] req_nr = '0;
  logic [NO_W:0] req_no = '0;
  logic [NF_W:0] req_nf = '0;
  logic [NB_W:0] req_nb = '0;
  logic [1:0] sel_reg = 2'd0;
  logic tick_us = 1'b1, pll_lock;
  logic busy, done, err, sel_we, pll_reset;
  logic [1:0] sel_wdata;
  logic [3:0] fld_wr;
  logic [NR_W-1:0] fld_nr;
  logic [NO_W-1:0] fld_no;
  logic [NF_W-1:0] fld_nf;
  logic [NB_W-1:0] fld_nb;

  int lock_mode = 0;            // 0 locks, 1 never locks, 2 refuses bad_nf
  logic [NF_W-1:0] bad_nf = '0;
  bit tick_alt = 1'b0;

  assign pll_lock = (lock_mode == 0) ? 1'b1 :
                    (lock_mode == 1) ? 1'b0 : (fld_nf != bad_nf);

  pll_reprog_seq #(.NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W), .NB_W(NB_W),
                   .POLL_LIMIT(POLL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_nr(req_nr), .req_no(req_no),
    .req_nf(req_nf), .req_nb(req_nb), .sel_cur(sel_reg), .pll_lock(pll_lock),
    .tick_us(tick_us), .busy(busy), .done(done), .err(err), .sel_we(sel_we),
    .sel_wdata(sel_wdata), .pll_reset(pll_reset), .fld_wr(fld_wr),
    .fld_nr(fld_nr), .fld_no(fld_no), .fld_nf(fld_nf), .fld_nb(fld_nb));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (sel_we) sel_reg <= sel_wdata;
  always @(negedge clk) tick_us <= tick_alt ? ~tick_us : 1'b1;

  typedef struct {
    bit err;
    int lat_lo, lat_hi;
    int nr, no, nf, nb;
    int sel_n, sel_fin, wr_n;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  int m_nr = 1, m_no = 1, m_nf = 1, m_nb = 1;
  int c0 = 0;
  bit op_norm = 1'b0;
  int sel_n = 0, wr_n = 0;
  bit order_bad = 1'b0, park_bad = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (fld_wr != 4'b0000) begin
        if (fld_wr != 4'(1 << (wr_n % 4)) || !pll_reset) order_bad = 1'b1;
        wr_n++;
      end
      if (sel_we) sel_n++;
      if (pll_reset && op_norm && sel_reg != 2'd0) park_bad = 1'b1;
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11 done without accepted request", 1, 0);
        end else begin
          e = q.pop_front();
          chk(err == e.err, "R7/R8 err flag", int'(err), int'(e.err));
          chk(cyc - c0 >= e.lat_lo && cyc - c0 <= e.lat_hi,
              "R5/R6 done latency", cyc - c0, e.lat_lo);
          chk(int'(fld_nr) == e.nr - 1, "R4 NR field", int'(fld_nr), e.nr - 1);
          chk(int'(fld_no) == e.no - 1, "R4 NO field", int'(fld_no), e.no - 1);
          chk(int'(fld_nf) == e.nf - 1, "R4 NF field", int'(fld_nf), e.nf - 1);
          chk(int'(fld_nb) == e.nb - 1, "R4 NB field", int'(fld_nb), e.nb - 1);
          chk(sel_n == e.sel_n, "R2/R10 selector writes", sel_n, e.sel_n);
          chk(int'(sel_reg) == e.sel_fin, "R2/R10 final selector",
              int'(sel_reg), e.sel_fin);
          chk(wr_n == e.wr_n, "R3 field write count", wr_n, e.wr_n);
          chk(!order_bad, "R3 write order under reset", int'(order_bad), 0);
          chk(!park_bad, "R2 parked during reset", int'(park_bad), 0);
          chk(!busy, "R9 busy low with done", int'(busy), 0);
        end
        sel_n = 0; wr_n = 0; order_bad = 1'b0; park_bad = 1'b0;
      end
    end
  end

  task automatic run_op(input int nr, input int no, input int nf, input int nb,
                        input logic [1:0] sel0);
    exp_t e;
    int s, s2;
    @(negedge clk);
    sel_reg = sel0;
    op_norm = (sel0 == 2'd1);
    s  = (nr * 125) / 6 + 1;
    s2 = (m_nr * 125) / 6 + 1;
    e.sel_fin = int'(sel0);
    e.sel_n = op_norm ? 2 : 0;
    if (lock_mode == 0) begin
      e.err = 1'b0; e.wr_n = 4;
      e.lat_lo = tick_alt ? 8 + 2 * s : 9 + s;
      e.lat_hi = tick_alt ? 9 + 2 * s : 9 + s;
      m_nr = nr; m_no = no; m_nf = nf; m_nb = nb;
    end else begin
      e.err = 1'b1; e.wr_n = 8;
      e.lat_lo = (lock_mode == 1) ? 14 + s + s2 + 2 * POLL : 15 + s + s2 + POLL;
      e.lat_hi = e.lat_lo;
    end
    e.nr = m_nr; e.no = m_no; e.nf = m_nf; e.nb = m_nb;
    q.push_back(e);
    req_nr = (NR_W+1)'(nr); req_no = (NO_W+1)'(no);
    req_nf = (NF_W+1)'(nf); req_nb = (NB_W+1)'(nb);
    start = 1'b1;
    @(negedge clk);
    c0 = cyc;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err, "R1 status after reset", int'({busy, done, err}), 0);
    chk(!pll_reset && !sel_we && fld_wr == 4'b0, "R1 controls after reset",
        int'({pll_reset, sel_we, fld_wr}), 0);
    chk(fld_nr == '0 && fld_no == '0 && fld_nf == '0 && fld_nb == '0,
        "R1 fields after reset", int'(fld_nf), 0);

    // R2 R6: normal selector, immediate lock
    lock_mode = 0;
    run_op(3, 2, 100, 50, 2'd1);
    wait_idle();
    // R10: slow selector untouched
    run_op(1, 4, 40, 20, 2'd0);
    wait_idle();
    // R10: deep selector untouched
    run_op(2, 3, 60, 30, 2'd2);
    wait_idle();
    // R7: PLL refuses NF=777, restore pass locks
    lock_mode = 2; bad_nf = NF_W'(776);
    run_op(5, 2, 777, 10, 2'd1);
    wait_idle();
    // R8: never locks, single restore then error
    lock_mode = 1;
    run_op(12, 1, 300, 5, 2'd0);
    wait_idle();
    // R11: start while busy ignored
    lock_mode = 0;
    run_op(4, 2, 200, 64, 2'd1);
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R11 second start lands while busy", int'(busy), 1);
    req_nr = 7'd9; req_no = 5'd7; req_nf = 14'd999; req_nb = 13'd99;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    // R5: gated timebase on alternate cycles
    tick_alt = 1'b1;
    run_op(1, 1, 50, 3, 2'd1);
    wait_idle();
    tick_alt = 1'b0;
    // R4 R5: full-scale ratios
    run_op(64, 16, 8192, 4096, 2'd1);
    wait_idle();

    summary();
    $finish;
  end

endmodule